// File: doc/BRIEF.md
# Vector paired add-with-carry unit

This block is a wide-integer arithmetic datapath. It treats three vectors of `VL` bits as arrays of element pairs and performs one independent add-with-carry per pair. For each pair, the even element of the accumulator vector is added to the odd element of the source vector. The carry-in is the lowest bit of the odd element of the carry vector. The truncated sum replaces the even slot. The carry out fills the odd slot as a zero-extended element.

Software builds multi-word additions by chaining these steps: the carry it produces sits where the next step reads its carry-in. A one-bit size input chooses 32-bit or 64-bit elements for each operation. With the default configuration the result is registered. It appears one clock after an input beat is accepted, marked by a valid output.

Top module: `vpac_top`

## Requirements
- R1: `size_sel`=0 selects 32-bit elements and `size_sel`=1 selects 64-bit elements. Element index 0 occupies the least-significant bits of every vector.
- R2: The unit processes VL/(2*element width) pairs, and each pair is computed without influence from any other pair.
- R3: For pair p, result element 2p equals accumulator element 2p plus source element 2p+1 plus the carry-in, truncated to the element width.
- R4: The carry-in of pair p is bit 0 of carry-vector element 2p+1. Every other bit of the carry vector has no effect on the result.
- R5: Result element 2p+1 holds the unsigned carry out of the pair's addition in its bit 0, with all higher bits zero.
- R6: Accumulator odd elements, source even elements and carry even elements have no effect on the result.
- R7: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `res_vec` shows the result of that beat. When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `res_vec` keeps its previous value.
- R8: A low `rst_n` at a rising edge is a synchronous reset. It clears `out_valid` and `res_vec` to zero.
- R9: An all-ones addend plus a zero addend with carry-in 1 gives a zero sum and a carry out of 1, in both element sizes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat is present |
| size_sel | input | 1 | Element size: 0 = 32-bit, 1 = 64-bit |
| acc_vec | input | VL | Accumulator vector (even elements are addends) |
| src_vec | input | VL | First source vector (odd elements are addends) |
| cry_vec | input | VL | Carry vector (bit 0 of odd elements is carry-in) |
| out_valid | output | 1 | Result is valid |
| res_vec | output | VL | Result vector |

## Verification
The assertions assume that `size_sel` and the three vectors carry known values whenever `in_valid` is high. The checks on the result look back through `$past` one cycle from a valid output. They rely on the beat being accepted exactly one edge earlier, outside reset. The bench drives every input on the falling edge with fully defined values, including during idle cycles. It raises `in_valid` only after reset is released, and it re-asserts reset in mid-run only between beats.

// File: rtl/vpac_pkg.sv
package vpac_pkg;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned DWORD_W = 2 * WORD_W;
    localparam int unsigned CHUNK_W = 2 * DWORD_W;   // one 64-bit pair = four words

    typedef enum logic {
        ESZ_WORD  = 1'b0,
        ESZ_DWORD = 1'b1
    } elem_size_e;
endpackage

// File: rtl/vpac_add.sv
module vpac_add #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] wide;

    always_comb begin
        wide   = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
    end
endmodule

// File: rtl/vpac_chunk.sv
module vpac_chunk
    import vpac_pkg::*;
(
    input  elem_size_e         esz_i,
    input  logic [CHUNK_W-1:0] acc_i,
    input  logic [CHUNK_W-1:0] src_i,
    input  logic [CHUNK_W-1:0] cry_i,
    output logic [CHUNK_W-1:0] res_o
);
    localparam int unsigned NWP = CHUNK_W / DWORD_W;   // word pairs per chunk

    logic [CHUNK_W-1:0] word_res;
    logic [DWORD_W-1:0] dw_sum;
    logic               dw_cout;

    // 32-bit elements: each 64-bit slice holds one pair
    for (genvar j = 0; j < NWP; j++) begin : g_wpair
        logic [WORD_W-1:0] s;
        logic              c;
        vpac_add #(.W(WORD_W)) add_i (
            .a_i   (acc_i[j*DWORD_W +: WORD_W]),
            .b_i   (src_i[j*DWORD_W + WORD_W +: WORD_W]),
            .cin_i (cry_i[j*DWORD_W + WORD_W]),
            .sum_o (s),
            .cout_o(c)
        );
        always_comb begin
            word_res[j*DWORD_W +: WORD_W]          = s;
            word_res[j*DWORD_W + WORD_W +: WORD_W] = {{(WORD_W-1){1'b0}}, c};
        end
    end

    // 64-bit elements: the whole chunk holds one pair
    vpac_add #(.W(DWORD_W)) dw_add_i (
        .a_i   (acc_i[DWORD_W-1:0]),
        .b_i   (src_i[CHUNK_W-1:DWORD_W]),
        .cin_i (cry_i[DWORD_W]),
        .sum_o (dw_sum),
        .cout_o(dw_cout)
    );

    always_comb begin
        if (esz_i == ESZ_DWORD) begin
            res_o = {{(DWORD_W-1){1'b0}}, dw_cout, dw_sum};
        end else begin
            res_o = word_res;
        end
    end
endmodule

// File: rtl/vpac_top.sv
module vpac_top
    import vpac_pkg::*;
#(
    parameter int unsigned VL      = 256,   // multiple of 128
    parameter bit          REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          size_sel,
    input  logic [VL-1:0] acc_vec,
    input  logic [VL-1:0] src_vec,
    input  logic [VL-1:0] cry_vec,
    output logic          out_valid,
    output logic [VL-1:0] res_vec
);
    localparam int unsigned NCHUNK = VL / CHUNK_W;

    elem_size_e    esz;
    logic [VL-1:0] comb_res;

    assign esz = elem_size_e'(size_sel);

    for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
        vpac_chunk chunk_i (
            .esz_i(esz),
            .acc_i(acc_vec[k*CHUNK_W +: CHUNK_W]),
            .src_i(src_vec[k*CHUNK_W +: CHUNK_W]),
            .cry_i(cry_vec[k*CHUNK_W +: CHUNK_W]),
            .res_o(comb_res[k*CHUNK_W +: CHUNK_W])
        );
    end

    if (REG_OUT) begin : g_reg
        typedef struct packed {
            logic          valid;
            logic [VL-1:0] data;
        } out_st_t;

        out_st_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.data = comb_res;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_valid = st_q.valid;
        assign res_vec   = st_q.data;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign res_vec   = comb_res;
    end
endmodule

// File: rtl/vpac_checker.sv
module vpac_checker #(
    parameter int unsigned VL      = 256,
    parameter bit          REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          size_sel,
    input logic [VL-1:0] acc_vec,
    input logic [VL-1:0] src_vec,
    input logic [VL-1:0] cry_vec,
    input logic          out_valid,
    input logic [VL-1:0] res_vec
);
    if (REG_OUT) begin : g_seq
        // R8
        assert_reset_clears_R8: assert property (@(posedge clk)
            !rst_n |=> (!out_valid && res_vec == '0));

        // R7
        assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(res_vec)));

        // R3 / R5: lowest 64-bit pair against previous inputs
        assert_dword_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(size_sel)) |->
            (res_vec[64:0] == ({1'b0, $past(acc_vec[63:0])}
                               + {1'b0, $past(src_vec[127:64])}
                               + {64'd0, $past(cry_vec[64])})));

        // R5: carry slot zero above bit 0
        assert_word_carry_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(size_sel)) |-> (res_vec[63:33] == '0));

        assert_dword_carry_zext_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(size_sel)) |-> (res_vec[127:65] == '0));

        // R3: lowest 32-bit pair
        assert_word_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !$past(size_sel)) |->
            (res_vec[32:0] == ({1'b0, $past(acc_vec[31:0])}
                               + {1'b0, $past(src_vec[63:32])}
                               + {32'd0, $past(cry_vec[32])})));
    end
endmodule

bind vpac_top vpac_checker #(.VL(VL), .REG_OUT(REG_OUT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .size_sel (size_sel),
    .acc_vec  (acc_vec),
    .src_vec  (src_vec),
    .cry_vec  (cry_vec),
    .out_valid(out_valid),
    .res_vec  (res_vec)
);

// File: tb/vpac_top_tb_top.sv
`timescale 1ns/1ps
module vpac_top_tb_top;
    localparam int unsigned VL = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          size_sel = 1'b0;
    logic [VL-1:0] acc_vec = '0;
    logic [VL-1:0] src_vec = '0;
    logic [VL-1:0] cry_vec = '0;
    logic          out_valid;
    logic [VL-1:0] res_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic          exp_valid = 1'b0;
    logic [VL-1:0] exp_res = '0;

    always #4 clk = ~clk;   // 125 MHz

    vpac_top #(.VL(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .size_sel(size_sel),
        .acc_vec(acc_vec), .src_vec(src_vec), .cry_vec(cry_vec),
        .out_valid(out_valid), .res_vec(res_vec)
    );

    // Behavioural reference: loop over pairs with integer arithmetic
    function automatic logic [VL-1:0] ref_model(input logic sz, input logic [VL-1:0] a,
                                                 input logic [VL-1:0] s, input logic [VL-1:0] c);
        logic [VL-1:0] r = '0;
        int esize = sz ? 64 : 32;
        int pairs = VL / (2 * esize);
        logic [63:0] mask = sz ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
        for (int p = 0; p < pairs; p++) begin
            logic [VL-1:0] ta = a >> (2 * p * esize);
            logic [VL-1:0] ts = s >> ((2 * p + 1) * esize);
            logic [VL-1:0] tc = c >> ((2 * p + 1) * esize);
            logic [64:0] sum = {1'b0, ta[63:0] & mask} + {1'b0, ts[63:0] & mask} + {64'd0, tc[0]};
            logic cout = sz ? sum[64] : sum[32];
            logic [VL-1:0] even = VL'(sum[63:0] & mask);
            r = r | (even << (2 * p * esize));
            r = r | (VL'(cout) << ((2 * p + 1) * esize));
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] rnd_vec();
        logic [VL-1:0] v;
        for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic compare(input string req);
        n_cmp++;
        if (out_valid !== exp_valid || res_vec !== exp_res) begin
            n_bad++;
            $display("FAIL %s: valid=%0b res=%h expected valid=%0b res=%h",
                     req, out_valid, res_vec, exp_valid, exp_res);
        end
    endtask

    // Called at a falling edge: drive, advance one edge, compare at next falling edge
    task automatic beat(input logic v, input logic sz, input logic [VL-1:0] a,
                        input logic [VL-1:0] s, input logic [VL-1:0] c, input string req);
        in_valid = v; size_sel = sz; acc_vec = a; src_vec = s; cry_vec = c;
        if (!rst_n) begin
            exp_valid = 1'b0; exp_res = '0;
        end else begin
            exp_valid = v;
            if (v) exp_res = ref_model(sz, a, s, c);
        end
        @(negedge clk);
        compare(req);
    endtask

    initial begin
        logic [VL-1:0] ones = '1;
        logic [VL-1:0] a, s, c;
        @(negedge clk);
        @(negedge clk);
        compare("R8 reset state");
        rst_n = 1'b1;

        // R1/R3 random, both sizes
        for (int i = 0; i < 6; i++) beat(1'b1, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), "R1 R3 word random");
        for (int i = 0; i < 6; i++) beat(1'b1, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R1 R3 dword random");

        // R9 carry chain: all-ones + 0 + cin 1 in every pair
        beat(1'b1, 1'b0, ones, '0, ones, "R9 word all-ones carry");
        beat(1'b1, 1'b1, ones, '0, ones, "R9 dword all-ones carry");
        beat(1'b1, 1'b0, ones, ones, ones, "R5 word max plus max plus 1");
        beat(1'b1, 1'b1, ones, ones, ones, "R5 dword max plus max plus 1");

        // R4: carry vector with bit 0 of every 32-bit word clear, rest set
        c = '0;
        for (int i = 0; i < VL / 32; i++) c[i*32 +: 32] = 32'hFFFF_FFFE;
        beat(1'b1, 1'b0, ones, '0, c, "R4 word cin ignores upper bits");
        beat(1'b1, 1'b1, ones, '0, c, "R4 dword cin ignores upper bits");

        // R6: only odd acc / even src / even cry nonzero -> inputs to ignore
        a = '0; s = '0; c = '0;
        for (int i = 0; i < VL / 64; i++) begin
            a[i*64 + 32 +: 32] = $urandom;
            s[i*64 +: 32]      = $urandom;
            c[i*64 +: 32]      = 32'hFFFF_FFFF;
        end
        beat(1'b1, 1'b0, a, s, c, "R6 word ignored lanes");
        a = '0; s = '0; c = '0;
        for (int i = 0; i < VL / 128; i++) begin
            a[i*128 + 64 +: 64] = {$urandom, $urandom};
            s[i*128 +: 64]      = {$urandom, $urandom};
            c[i*128 +: 64]      = '1;
        end
        beat(1'b1, 1'b1, a, s, c, "R6 dword ignored lanes");

        // R2: one pair saturated, others zero -> no cross-pair carry
        a = '0; c = '0;
        a[63:0] = '1; c[64] = 1'b1;
        beat(1'b1, 1'b1, a, '0, c, "R2 dword pair isolation");
        a = '0; c = '0;
        a[31:0] = '1; c[32] = 1'b1;
        beat(1'b1, 1'b0, a, '0, c, "R2 word pair isolation");

        // R7: idle cycles hold result, drop valid
        beat(1'b0, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R7 idle holds");
        beat(1'b0, 1'b0, ones, ones, ones, "R7 idle holds again");
        beat(1'b1, 1'b0, rnd_vec(), rnd_vec(), rnd_vec(), "R7 resume");

        // R8 mid-run reset
        rst_n = 1'b0;
        beat(1'b0, 1'b0, '0, '0, '0, "R8 mid-run reset");
        rst_n = 1'b1;
        beat(1'b1, 1'b1, rnd_vec(), rnd_vec(), rnd_vec(), "R1 after reset");

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule